// File: doc/BRIEF.md
# Receive Fill Hysteresis Flow Control

This block tracks how full a 64-entry receive buffer is and uses that fill level to tell the far end when to stop sending. It counts push and pop strobes in an internal saturating counter. The count is compared with two programmable levels. When the fill climbs to the halt level, the block raises `tx_halted` and drives the active-low request-to-send line high. It keeps that state until the fill drains to the resume level, and then lets the far end send again. Between the two levels it keeps its last decision, which gives the control loop hysteresis.

Both levels are 4-bit codes held in one 16-bit control word, and each level in entries is four times its code. A write to the control word takes effect on the next clock. The block also reports two set-up hazards. The first is an ordering error: the halt code is not strictly above the resume code while flow control is enabled. The second is a stall risk: in interrupt-driven mode the halt level falls below the receive interrupt trigger level that the caller supplies.

Top module: `rx_fill_flowctl`

## Requirements
- R1: After reset, `ctl_rdata` reads 16'h000F (halt code 4'hF, resume code 4'h0). `rts_n` is 0, and `tx_halted`, `cfg_err` and `stall_risk` are 0.
- R2: In the control word, bits 3:0 hold the halt code and bits 7:4 hold the resume code. Each level in entries is the code times four. Bits 15:8 always read 0, and writes to them have no effect. A write appears on `ctl_rdata` one clock after `ctl_wr` is sampled.
- R3: The fill count rises by one on a lone `push` and falls by one on a lone `pop`. It stays unchanged when both strobes are high. It saturates at 64 and at 0.
- R4: While enabled, when the fill count reaches or exceeds the halt level, `tx_halted` goes to 1 and `rts_n` goes to 1 on the clock edge after the count was updated.
- R5: While enabled, when the fill count is at or below the resume level and below the halt level, `tx_halted` and `rts_n` go to 0 on the clock edge after the count was updated. If the two conditions overlap, halting wins.
- R6: While the fill count is strictly between the resume level and the halt level, `tx_halted` keeps its previous value.
- R7: While `fc_enable` is 0, the halted state is cleared on the next edge and `rts_n` is 0. Pushes made while disabled never raise `tx_halted`.
- R8: A new threshold is used in the comparison from the edge after the write. The hysteresis state is then re-evaluated, so `tx_halted` can change one edge after the write.
- R9: `cfg_err` is 1 exactly when `fc_enable` is 1 and the stored halt code is less than or equal to the stored resume code.
- R10: `stall_risk` is 1 exactly when `fc_enable` and `irq_mode` are both 1 and four times the halt code is below `rx_trig_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_enable | input | 1 | Enables automatic flow control |
| irq_mode | input | 1 | The receive path is drained by interrupt, not by DMA |
| rx_trig_level | input | 7 | Receive interrupt trigger level, in entries |
| push | input | 1 | One entry was written into the receive buffer |
| pop | input | 1 | One entry was read out of the receive buffer |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read-back |
| rts_n | output | 1 | Request-to-send, active low; high asks the far end to stop |
| tx_halted | output | 1 | The far end is currently held off |
| cfg_err | output | 1 | The halt code is not above the resume code while enabled |
| stall_risk | output | 1 | The halt level is below the interrupt trigger level in interrupt mode |

## Verification
The fill count is registered on the edge that samples a strobe, and the halt decision is registered one edge after that. A flow-control change is therefore due two edges after the last push or pop is driven. A threshold write changes `ctl_rdata`, `cfg_err` and `stall_risk` after one edge, and `tx_halted` after two. The bench drives inputs on falling edges. It first checks that `tx_halted` has not yet moved on the falling edge right after the strobe or write, and then checks the new value one cycle later. This pins each result to its exact cycle.

// File: rtl/fc_pkg.sv
// Package fc_pkg
// Shared sizing constants and helpers for the receive-fill flow controller.
// Assumes the threshold code is narrower than the fill counter.
package fc_pkg;
    localparam int FC_CODE_W = 4;
    localparam int FC_SCALE_SHIFT = 2;

    // Scale a threshold code into a fill level of the given counter width.
    function automatic logic [15:0] fc_code_to_level(input logic [FC_CODE_W-1:0] code);
        return 16'(code) << FC_SCALE_SHIFT;
    endfunction
endpackage

// File: rtl/fc_thresh_regs.sv
// Module fc_thresh_regs
// Holds the halt and resume threshold codes in one control word.
// Reserved upper bits read as zero and ignore writes.
// Assumes WORD_W >= 2*CODE_W.
module fc_thresh_regs #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] HALT_RST = '1,
    parameter logic [CODE_W-1:0] RESUME_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CODE_W-1:0] halt_code,
    output logic [CODE_W-1:0] resume_code,
    output logic [WORD_W-1:0] rdata
);
    localparam int FIELD_W = 2 * CODE_W;

    // Capture both threshold fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_code   <= HALT_RST;
            resume_code <= RESUME_RST;
        end else if (wr) begin
            halt_code   <= wdata[CODE_W-1:0];
            resume_code <= wdata[FIELD_W-1:CODE_W];
        end
    end

    // Assemble the read-back word and zero-pad the reserved bits.
    generate
        if (WORD_W > FIELD_W) begin : g_pad
            assign rdata = {{(WORD_W-FIELD_W){1'b0}}, resume_code, halt_code};
        end else begin : g_nopad
            assign rdata = {resume_code, halt_code};
        end
    endgenerate
endmodule

// File: rtl/fc_fill_count.sv
// Module fc_fill_count
// Up/down occupancy counter for the receive buffer.
// Saturates at DEPTH and at zero; simultaneous push and pop cancel.
module fc_fill_count #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    // Track occupancy with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   if (fill != FULL) fill <= fill + 1'b1;
                2'b01:   if (fill != '0)   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/fc_hysteresis.sv
// Module fc_hysteresis
// Two-level hysteresis comparator that decides whether the far end is halted.
// The halt condition has priority when the two levels overlap.
// Assumes CNT_W is wide enough to hold (2**CODE_W - 1) << SHIFT.
module fc_hysteresis #(
    parameter int CNT_W = 7,
    parameter int CODE_W = 4,
    parameter int SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  fill,
    input  logic [CODE_W-1:0] halt_code,
    input  logic [CODE_W-1:0] resume_code,
    output logic [CNT_W-1:0]  halt_lvl,
    output logic [CNT_W-1:0]  resume_lvl,
    output logic              halted
);
    localparam int PAD_W = CNT_W - CODE_W;

    // Scale both codes into fill-count units.
    assign halt_lvl   = {{PAD_W{1'b0}}, halt_code} << SHIFT;
    assign resume_lvl = {{PAD_W{1'b0}}, resume_code} << SHIFT;

    logic at_high;
    logic at_low;

    // Compare the fill count against both levels.
    always_comb begin
        at_high = (fill >= halt_lvl);
        at_low  = (fill <= resume_lvl);
    end

    // Register the hysteresis decision; disabling clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (!enable) begin
            halted <= 1'b0;
        end else if (at_high) begin
            halted <= 1'b1;
        end else if (at_low) begin
            halted <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_fill_flowctl.sv
// Module rx_fill_flowctl
// Top level of the receive-fill flow controller. It counts buffer occupancy,
// holds the threshold word, drives an active-low RTS with hysteresis and
// flags unsafe threshold set-ups. Assumes push and pop are single-cycle
// strobes, one per transferred entry.
module rx_fill_flowctl #(
    parameter int DEPTH = 64,
    parameter int WORD_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_enable,
    input  logic              irq_mode,
    input  logic [CNT_W-1:0]  rx_trig_level,
    input  logic              push,
    input  logic              pop,
    input  logic              ctl_wr,
    input  logic [WORD_W-1:0] ctl_wdata,
    output logic [WORD_W-1:0] ctl_rdata,
    output logic              rts_n,
    output logic              tx_halted,
    output logic              cfg_err,
    output logic              stall_risk
);
    import fc_pkg::*;

    logic [FC_CODE_W-1:0] halt_code;
    logic [FC_CODE_W-1:0] resume_code;
    logic [CNT_W-1:0]     fill_q;
    logic [CNT_W-1:0]     halt_lvl;
    logic [CNT_W-1:0]     resume_lvl;
    logic                 halted_q;

    fc_thresh_regs #(
        .WORD_W     (WORD_W),
        .CODE_W     (FC_CODE_W),
        .HALT_RST   ('1),
        .RESUME_RST ('0)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctl_wr),
        .wdata       (ctl_wdata),
        .halt_code   (halt_code),
        .resume_code (resume_code),
        .rdata       (ctl_rdata)
    );

    fc_fill_count #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .fill  (fill_q)
    );

    fc_hysteresis #(
        .CNT_W  (CNT_W),
        .CODE_W (FC_CODE_W),
        .SHIFT  (FC_SCALE_SHIFT)
    ) u_hyst (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (fc_enable),
        .fill        (fill_q),
        .halt_code   (halt_code),
        .resume_code (resume_code),
        .halt_lvl    (halt_lvl),
        .resume_lvl  (resume_lvl),
        .halted      (halted_q)
    );

    // Drive the line and status outputs from the halted state.
    assign tx_halted = halted_q;
    assign rts_n     = halted_q;

    // Flag threshold set-ups that can misbehave while flow control is active.
    always_comb begin
        cfg_err    = fc_enable && (halt_code <= resume_code);
        stall_risk = fc_enable && irq_mode && (halt_lvl < rx_trig_level);
    end
endmodule

// File: rtl/fc_flowctl_chk.sv
// Module fc_flowctl_chk
// Property checker bound to rx_fill_flowctl. It watches the counter bounds,
// the register write path and the hysteresis decisions.
module fc_flowctl_chk #(
    parameter int DEPTH = 64,
    parameter int WORD_W = 16,
    parameter int CNT_W = 7,
    parameter int FIELD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fc_enable,
    input logic              push,
    input logic              pop,
    input logic              ctl_wr,
    input logic [WORD_W-1:0] ctl_wdata,
    input logic [WORD_W-1:0] ctl_rdata,
    input logic              rts_n,
    input logic              tx_halted,
    input logic [CNT_W-1:0]  fill_q,
    input logic [CNT_W-1:0]  halt_lvl,
    input logic [CNT_W-1:0]  resume_lvl
);
    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH));

    // R3
    fill_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(fill_q));

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata[FIELD_W-1:0] == $past(ctl_wdata[FIELD_W-1:0])));

    // R4
    halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_enable && fill_q >= halt_lvl) |=> (tx_halted && rts_n));

    // R5
    resume_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_enable && fill_q <= resume_lvl && fill_q < halt_lvl) |=> !tx_halted);

    // R6
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_enable && fill_q > resume_lvl && fill_q < halt_lvl) |=> $stable(tx_halted));

    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_enable |=> (!tx_halted && !rts_n));
endmodule

bind rx_fill_flowctl fc_flowctl_chk #(
    .DEPTH   (DEPTH),
    .WORD_W  (WORD_W),
    .CNT_W   (CNT_W),
    .FIELD_W (2 * fc_pkg::FC_CODE_W)
) u_fc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc_enable  (fc_enable),
    .push       (push),
    .pop        (pop),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .rts_n      (rts_n),
    .tx_halted  (tx_halted),
    .fill_q     (fill_q),
    .halt_lvl   (halt_lvl),
    .resume_lvl (resume_lvl)
);

// File: tb/test_rx_fill_flowctl.sv
// Directed bench for rx_fill_flowctl. Inputs change on falling edges and
// outputs are sampled on falling edges.
module test_rx_fill_flowctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_enable = 1'b0;
    logic        irq_mode = 1'b0;
    logic [6:0]  rx_trig_level = '0;
    logic        push = 1'b0;
    logic        pop = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        rts_n;
    logic        tx_halted;
    logic        cfg_err;
    logic        stall_risk;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    rx_fill_flowctl i_rx_fill_flowctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fc_enable     (fc_enable),
        .irq_mode      (irq_mode),
        .rx_trig_level (rx_trig_level),
        .push          (push),
        .pop           (pop),
        .ctl_wr        (ctl_wr),
        .ctl_wdata     (ctl_wdata),
        .ctl_rdata     (ctl_rdata),
        .rts_n         (rts_n),
        .tx_halted     (tx_halted),
        .cfg_err       (cfg_err),
        .stall_risk    (stall_risk)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input int n);
        for (int i = 0; i < n; i++) begin
            push = p;
            pop  = q;
            @(negedge clk);
        end
        push = 1'b0;
        pop  = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        ctl_wr    = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", ctl_rdata, 16'h000F);
        chk("R1 rts_n", 16'(rts_n), 16'h0);
        chk("R1 halted", 16'(tx_halted), 16'h0);
        chk("R1 cfg_err", 16'(cfg_err), 16'h0);
        chk("R1 stall", 16'(stall_risk), 16'h0);
    endtask

    task automatic t_regs();
        wr(16'hAB73);
        chk("R2 reserved", ctl_rdata, 16'h0073);
        wr(16'h0012);
        chk("R2 fields", ctl_rdata, 16'h0012);
    endtask

    task automatic t_halt_resume();
        fc_enable = 1'b1;
        step(1, 0, 7); step(0, 0, 1);
        chk("R4 below", 16'(tx_halted), 16'h0);
        step(1, 0, 1);
        chk("R4 one edge late", 16'(tx_halted), 16'h0);
        step(0, 0, 1);
        chk("R4 halted", 16'(tx_halted), 16'h1);
        chk("R4 rts_n", 16'(rts_n), 16'h1);
        step(0, 1, 3); step(0, 0, 1);
        chk("R6 hold high", 16'(tx_halted), 16'h1);
        step(0, 1, 1);
        chk("R5 one edge late", 16'(tx_halted), 16'h1);
        step(0, 0, 1);
        chk("R5 released", 16'(rts_n), 16'h0);
        step(1, 0, 3); step(0, 0, 1);
        chk("R6 hold low", 16'(tx_halted), 16'h0);
    endtask

    task automatic t_count_low();
        step(1, 1, 5); step(0, 0, 1);
        chk("R3 cancel", 16'(tx_halted), 16'h0);
        step(1, 0, 1); step(0, 0, 1);
        chk("R3 cancel reach", 16'(tx_halted), 16'h1);
        step(0, 1, 12); step(0, 0, 1);
        chk("R3 empty", 16'(tx_halted), 16'h0);
        step(1, 0, 7); step(0, 0, 1);
        chk("R3 no wrap", 16'(tx_halted), 16'h0);
        step(1, 0, 1); step(0, 0, 1);
        chk("R3 refill", 16'(tx_halted), 16'h1);
        step(0, 1, 4); step(0, 0, 1);
        chk("R5 drain", 16'(tx_halted), 16'h0);
    endtask

    task automatic t_retune();
        step(1, 0, 3); step(0, 0, 1);
        wr(16'h0001);
        chk("R8 not yet", 16'(tx_halted), 16'h0);
        step(0, 0, 1);
        chk("R8 applied", 16'(tx_halted), 16'h1);
    endtask

    task automatic t_cfg();
        wr(16'h0033);
        chk("R9 equal", 16'(cfg_err), 16'h1);
        wr(16'h0034);
        chk("R9 ok", 16'(cfg_err), 16'h0);
        wr(16'h0052);
        chk("R9 inverted", 16'(cfg_err), 16'h1);
        fc_enable = 1'b0;
        step(0, 0, 1);
        chk("R9 disabled", 16'(cfg_err), 16'h0);
        fc_enable = 1'b1;
    endtask

    task automatic t_stall();
        irq_mode = 1'b1;
        rx_trig_level = 7'd20;
        wr(16'h0004);
        chk("R10 low", 16'(stall_risk), 16'h1);
        wr(16'h0005);
        chk("R10 equal", 16'(stall_risk), 16'h0);
        wr(16'h0004);
        irq_mode = 1'b0;
        step(0, 0, 1);
        chk("R10 dma", 16'(stall_risk), 16'h0);
    endtask

    task automatic t_disable();
        wr(16'h0001); step(0, 0, 1);
        chk("R7 pre", 16'(tx_halted), 16'h1);
        fc_enable = 1'b0;
        step(0, 0, 1);
        chk("R7 cleared", 16'(tx_halted), 16'h0);
        chk("R7 rts_n", 16'(rts_n), 16'h0);
        step(1, 0, 5); step(0, 0, 1);
        chk("R7 pushes", 16'(rts_n), 16'h0);
        fc_enable = 1'b1;
        step(0, 0, 1);
        chk("R7 re-enable", 16'(tx_halted), 16'h1);
    endtask

    task automatic t_count_high();
        step(0, 1, 20);
        wr(16'h00EF);
        step(1, 0, 70); step(0, 0, 1);
        chk("R3 full halted", 16'(tx_halted), 16'h1);
        step(0, 1, 7); step(0, 0, 1);
        chk("R3 above resume", 16'(tx_halted), 16'h1);
        step(0, 1, 1); step(0, 0, 1);
        chk("R3 saturated top", 16'(tx_halted), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_halt_resume();
        t_count_low();
        t_retune();
        t_cfg();
        wr(16'h0012);
        t_stall();
        t_disable();
        t_count_high();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule